// File: doc/BRIEF.md
# Bus Efficiency and Read Latency Monitor

This block watches one AXI4 manager/subordinate link without driving it. It tallies write-data beats and read-data beats that complete a handshake. It also counts the cycles during which traffic is in flight. For every read command it measures the round trip from the first cycle the address is offered to the cycle its final data beat is taken, and it keeps the smallest and largest of these round trips.

A 3-bit select code picks which 32-bit result is shown on one shared output bus. A sticky flag reports that the observed traffic has finished. External logic reads the counters through the select bus and works out bus efficiency from them.

Start times are kept in a small table indexed by transaction ID, so responses that return out of order are timed against their own command.

Top module: `bus_eff_monitor`

## Requirements
- R1: Select code 3'b000 shows the number of cycles with both wvalid and wready high; a cycle with only one of them high is not counted.
- R2: Select code 3'b001 shows the number of cycles with both rvalid and rready high, counting every beat whether or not rlast is set.
- R3: Select code 3'b010 shows the active-cycle count. It counts every cycle from the first cycle in which awvalid or arvalid is high, through the cycle in which done first becomes set. It then holds its value.
- R4: A read's latency is the number of cycles from the first cycle its arvalid is high to the cycle its rlast beat completes a handshake. Each ID keeps its own start time, so out-of-order responses are timed correctly.
- R5: Select code 3'b100 shows the minimum read latency, and 3'b101 shows the maximum. Both values are zero-extended. After reset the minimum is all ones of the latency width and the maximum is zero.
- R6: Select codes 3'b011, 3'b110 and 3'b111 show zero.
- R7: done rises at the clock edge where traffic_done is high, no read is outstanding and arvalid is low. Once set, it stays set until reset.
- R8: The beat counters and the active counter stop at their all-ones value instead of wrapping.
- R9: After reset, all counts are zero and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| awvalid | input | 1 | Write address valid |
| awready | input | 1 | Write address ready |
| wvalid | input | 1 | Write data valid |
| wready | input | 1 | Write data ready |
| arvalid | input | 1 | Read address valid |
| arready | input | 1 | Read address ready |
| arid | input | ID_W | Read address ID |
| rvalid | input | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rid | input | ID_W | Read data ID |
| rlast | input | 1 | Final beat of a read burst |
| traffic_done | input | 1 | Driver has issued all its traffic |
| sel | input | 3 | Result select code |
| result | output | 32 | Selected counter or latency |
| done | output | 1 | Observed traffic has completed |

## Verification
The assertions assume the following about the link:
- At most one read is outstanding per ID.
- Every rlast beat belongs to an ID that has a command in flight.
- No ID is issued and retired in the same cycle.
- Every latency stays below the range of the latency width.

The stimulus keeps within these limits. It issues reads one at a time, except for one out-of-order pair that uses two different IDs. It also bounds every round trip to a few cycles.

// File: rtl/bus_eff_monitor.sv
module bus_eff_monitor #(
  parameter int ID_W  = 2,
  parameter int CNT_W = 32,
  parameter int LAT_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            awvalid,
  input  logic            awready,
  input  logic            wvalid,
  input  logic            wready,
  input  logic            arvalid,
  input  logic            arready,
  input  logic [ID_W-1:0] arid,
  input  logic            rvalid,
  input  logic            rready,
  input  logic [ID_W-1:0] rid,
  input  logic            rlast,
  input  logic            traffic_done,
  input  logic [2:0]      sel,
  output logic [31:0]     result,
  output logic            done
);
  localparam int N_ID = 1 << ID_W;
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] wr_cnt, rd_cnt, act_cnt;
  logic [LAT_W-1:0] now, hold_ts, min_lat, max_lat;
  logic [LAT_W-1:0] start_ts [N_ID];
  logic [N_ID-1:0]  busy;
  logic             ar_hold, started, done_q;

  wire w_hs  = wvalid & wready;
  wire r_hs  = rvalid & rready;
  wire r_end = r_hs & rlast;
  wire ar_hs = arvalid & arready;
  wire aw_unused = awready;

  wire [LAT_W-1:0] ar_ts  = ar_hold ? hold_ts : now;
  wire [LAT_W-1:0] lat    = now - start_ts[rid];
  wire [N_ID-1:0]  ar_bit = ar_hs ? (N_ID'(1) << arid) : '0;
  wire [N_ID-1:0]  r_bit  = r_end ? (N_ID'(1) << rid) : '0;
  wire [N_ID-1:0]  busy_nxt = (busy | ar_bit) & ~r_bit;
  wire             run = (started | awvalid | arvalid) & ~done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_cnt  <= '0;
      rd_cnt  <= '0;
      act_cnt <= '0;
      now     <= '0;
      hold_ts <= '0;
      ar_hold <= 1'b0;
      started <= 1'b0;
      done_q  <= 1'b0;
      busy    <= '0;
      min_lat <= '1;
      max_lat <= '0;
      for (int i = 0; i < N_ID; i++) start_ts[i] <= '0;
    end else begin
      now <= now + 1'b1;
      if (w_hs && wr_cnt != CMAX) wr_cnt <= wr_cnt + 1'b1;
      if (r_hs && rd_cnt != CMAX) rd_cnt <= rd_cnt + 1'b1;
      if (run && act_cnt != CMAX) act_cnt <= act_cnt + 1'b1;
      if (awvalid | arvalid) started <= 1'b1;

      if (arvalid && !arready && !ar_hold) begin
        ar_hold <= 1'b1;
        hold_ts <= now;
      end else if (ar_hs) begin
        ar_hold <= 1'b0;
      end
      if (ar_hs) start_ts[arid] <= ar_ts;

      busy <= busy_nxt;
      if (r_end) begin
        if (lat < min_lat) min_lat <= lat;
        if (lat > max_lat) max_lat <= lat;
      end
      if (traffic_done && !arvalid && busy_nxt == '0) done_q <= 1'b1;
    end
  end

  always_comb begin
    case (sel)
      3'b000:  result = 32'(wr_cnt);
      3'b001:  result = 32'(rd_cnt);
      3'b010:  result = 32'(act_cnt);
      3'b100:  result = 32'(min_lat);
      3'b101:  result = 32'(max_lat);
      default: result = 32'd0;
    endcase
  end

  assign done = done_q;

  assert_wr_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(wvalid && wready) |=> $stable(wr_cnt));
  assert_rd_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(rvalid && rready) |=> $stable(rd_cnt));
  assert_active_frozen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> $stable(act_cnt));
  assert_resp_tracked_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && rready && rlast) |-> busy[rid]);
  assert_min_le_max_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (max_lat != '0) |-> (min_lat <= max_lat));
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> done_q);
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt == CMAX) |=> (wr_cnt == CMAX));
endmodule

// File: tb/tb_bus_eff_monitor.sv
module tb_bus_eff_monitor;
  localparam int ID_W = 2, CNT_W = 9, LAT_W = 8;
  localparam int CMAX = (1 << CNT_W) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic awvalid = 0, awready = 0, wvalid = 0, wready = 0, arvalid = 0, arready = 0;
  logic rvalid = 0, rready = 0, rlast = 0, traffic_done = 0;
  logic [ID_W-1:0] arid = '0, rid = '0;
  logic [2:0] sel = '0;
  logic [31:0] result;
  logic done;

  always #5 clk = ~clk;

  bus_eff_monitor #(.ID_W(ID_W), .CNT_W(CNT_W), .LAT_W(LAT_W)) dut (
    .clk(clk), .rst_n(rst_n), .awvalid(awvalid), .awready(awready),
    .wvalid(wvalid), .wready(wready), .arvalid(arvalid), .arready(arready),
    .arid(arid), .rvalid(rvalid), .rready(rready), .rid(rid), .rlast(rlast),
    .traffic_done(traffic_done), .sel(sel), .result(result), .done(done));

  int checks = 0, fails = 0;
  int m_wr = 0, m_rd = 0, m_act = 0, m_out = 0;
  bit m_started = 0, m_done = 0;
  int em = 255, eM = 0;

  always @(posedge clk) begin
    if (rst_n) begin
      int nout;
      if ((m_started || awvalid || arvalid) && !m_done && m_act < CMAX) m_act++;
      if (awvalid || arvalid) m_started = 1;
      if (wvalid && wready && m_wr < CMAX) m_wr++;
      if (rvalid && rready && m_rd < CMAX) m_rd++;
      nout = m_out + ((arvalid && arready) ? 1 : 0) - ((rvalid && rready && rlast) ? 1 : 0);
      m_out = nout;
      if (traffic_done && !arvalid && nout == 0) m_done = 1;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic look(input logic [2:0] code, input string tag, input int exp);
    sel = code;
    #1;
    check(tag, int'(result), exp);
  endtask

  task automatic note_lat(input int l);
    if (l < em) em = l;
    if (l > eM) eM = l;
  endtask

  task automatic do_read(input int id, input int d, input int len, input bit pre);
    arid = ID_W'(id);
    for (int i = 0; i <= d; i++) begin
      arvalid = 1; arready = (i == d);
      @(negedge clk);
    end
    arvalid = 0; arready = 0;
    for (int j = 1; j < len; j++) begin
      if (j == len - 1) begin
        rvalid = 1; rready = pre; rlast = 0; rid = ID_W'(id);
      end
      @(negedge clk);
      rvalid = 0; rready = 0;
    end
    rvalid = 1; rready = 1; rlast = 1; rid = ID_W'(id);
    @(negedge clk);
    rvalid = 0; rready = 0; rlast = 0;
    note_lat(d + len);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R9 R5 R6: reset values across every select code
    look(3'b000, "R9 wr", 0);
    look(3'b001, "R9 rd", 0);
    look(3'b010, "R9 act", 0);
    look(3'b011, "R6 code3", 0);
    look(3'b100, "R5 min reset", 255);
    look(3'b101, "R5 max reset", 0);
    look(3'b110, "R6 code6", 0);
    look(3'b111, "R6 code7", 0);
    check("R9 done", int'(done), 0);

    // R1: write beats with mixed valid/ready patterns
    for (int i = 0; i < 24; i++) begin
      awvalid = (i == 0); awready = (i == 0);
      wvalid = (i % 4 != 3); wready = (i % 3 != 0);
      @(negedge clk);
    end
    awvalid = 0; awready = 0; wvalid = 0; wready = 0;
    @(negedge clk);
    look(3'b000, "R1 wr beats", 12);
    look(3'b001, "R2 rd untouched", 0);

    // R4: out-of-order responses, id1 then id2 issued, id2 returns first
    arvalid = 1; arready = 1; arid = 2'd1; @(negedge clk);
    arid = 2'd2; @(negedge clk);
    arvalid = 0; arready = 0; @(negedge clk);
    rvalid = 1; rready = 1; rlast = 1; rid = 2'd2; @(negedge clk);
    rvalid = 0; rready = 0; rlast = 0;
    repeat (5) @(negedge clk);
    rvalid = 1; rready = 1; rlast = 1; rid = 2'd1; @(negedge clk);
    rvalid = 0; rready = 0; rlast = 0;
    note_lat(2); note_lat(9);
    look(3'b100, "R4 ooo min", 2);
    look(3'b101, "R4 ooo max", 9);

    // R4 R5 R2: sweep address-ready delay and response distance
    for (int d = 0; d < 3; d++)
      for (int len = 1; len <= 5; len++) begin
        do_read((d * 5 + len) % 4, d, len, len % 2 == 0);
        look(3'b100, "R5 min", em);
        look(3'b101, "R5 max", eM);
      end
    look(3'b001, "R2 rd beats", m_rd);
    look(3'b000, "R1 wr after reads", 12);

    // R7 R3: done waits for the outstanding read
    arvalid = 1; arready = 1; arid = 2'd3; @(negedge clk);
    arvalid = 0; arready = 0; traffic_done = 1;
    repeat (3) @(negedge clk);
    check("R7 done held low", int'(done), 0);
    rvalid = 1; rready = 1; rlast = 1; rid = 2'd3; @(negedge clk);
    rvalid = 0; rready = 0; rlast = 0;
    check("R7 done set", int'(done), 1);
    look(3'b010, "R3 active", m_act);
    repeat (5) @(negedge clk);
    look(3'b010, "R3 active frozen", m_act);
    check("R7 done sticky", int'(done), 1);

    // R8: saturation of the write counter
    wvalid = 1; wready = 1;
    repeat (520) @(negedge clk);
    wvalid = 0; wready = 0;
    @(negedge clk);
    look(3'b000, "R8 wr saturated", CMAX);
    look(3'b011, "R6 code3 busy", 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule